// File: doc/BRIEF.md
# Real-Time Counter and Periodic Timer Unit

This unit keeps a free-running real-time count and a programmable periodic timer behind a small register interface. The real-time count is 40 bits wide by default and advances once per pulse of a slow tick input, nominally 32.768 kHz. At that rate, whole seconds are the low word shifted right by 15 combined with the high word shifted left by 17. Software reads the count as a narrow high word and a wide low word. Each part has its own freeze control, and a clear control holds the whole count at zero. The periodic timer is a down-counter driven by a faster tick input. It expires once every reload+1 ticks, where software loads reload with the timer tick frequency divided by the wanted rate, minus one.

Three event sources are kept as sticky status bits: count rollover, alarm match and periodic expiry. A 1 written to a status bit clears it. An enable bit gates each status bit onto its own interrupt line. Both tick inputs are single-cycle enable pulses in the system clock domain.

The register interface is plain control, not a stream. A write happens in any cycle in which `wr_en` is high. Read data is a combinational function of `addr`. The register map is: 0 control, 1 count low, 2 count high, 3 reload, 4 alarm low, 5 alarm high, 6 status, 7 interrupt enable.

Top module: `rtc_timer_unit`

## Requirements
- R1: After reset, every readable register returns zero and all three interrupt lines are low.
- R2: Each `rtc_tick` pulse adds one to the count. The low word is at address 1. The high word is at address 2 and advances when the low word wraps. Register bits above each field's width read as zero. With no tick in between, repeated reads return equal values.
- R3: While control bit 2 is set, the low word holds and no carry reaches the high word. While control bit 1 is set, the high word holds and the low word keeps counting and wrapping.
- R4: While control bit 4 is set, the count is zero and does not advance. After the bit is cleared, counting resumes from zero.
- R5: Writing the value zero to the control register clears the count, reloads the periodic down-counter and clears all three status bits.
- R6: Control bit 0 enables the periodic timer. Once enabled, it sets status bit 29 on every (reload+1)-th `tmr_tick`, where reload is written at address 3, and then starts again from reload.
- R7: While control bit 3 is set, `tmr_tick` pulses do not advance the periodic timer. Counting continues from the held value when the bit is released.
- R8: Status bit 30 is set on the tick at which the count first becomes equal to the alarm value. The alarm low part is at address 4 and the high part at address 5. The bit is not set again while the count stays put.
- R9: Status bit 31 is set on the tick at which the count wraps from all ones to zero.
- R10: Status bits (address 6, bits 31..29) stay set until a 1 is written to them. Each drives its interrupt line only while the matching bit at address 7 is set. Status reads back unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | Slow count enable pulse |
| tmr_tick | input | 1 | Periodic timer enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_roll | output | 1 | Rollover interrupt |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_per | output | 1 | Periodic interrupt |

## Verification
The assertions check on every cycle that:
- a held clear keeps the count at zero;
- the count stands still without a tick, and the low word stands still while frozen;
- a zero write to the control register empties the count and the interrupts;
- a raised periodic interrupt stays up until software touches status or enable.

Only the bench scenarios can show that:
- expiry comes on exactly the (reload+1)-th timer tick;
- the alarm fires on the matching tick and only once;
- the rollover lands on the wrap from all ones;
- the carry into the high word and the high-word freeze interact correctly.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNTLO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTHI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RELD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_ALMLO = 3'd4;
  localparam logic [ADDR_W-1:0] A_ALMHI = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd7;

  // event index 0 = periodic, 1 = alarm, 2 = rollover; word bits 29..31
  localparam int N_EVT  = 3;
  localparam int EVT_LSB = 29;

  typedef struct packed {
    logic clr;      // bit 4
    logic frz_per;  // bit 3
    logic frz_lo;   // bit 2
    logic frz_hi;   // bit 1
    logic per_en;   // bit 0
  } ctrl_t;
endpackage

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int LO_W = 32,
  parameter int HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 clr,
  input  logic                 zero,
  input  logic                 frz_lo,
  input  logic                 frz_hi,
  input  logic [HI_W+LO_W-1:0] alarm,
  output logic [LO_W-1:0]      cnt_lo,
  output logic [HI_W-1:0]      cnt_hi,
  output logic                 roll_evt,
  output logic                 alarm_evt
);
  logic [LO_W-1:0] lo_nxt;
  logic [HI_W-1:0] hi_nxt;
  logic            lo_full, carry, advance;

  assign lo_full = &cnt_lo;
  assign carry   = !frz_lo && lo_full;
  assign advance = tick && !clr && !zero;

  always_comb begin
    lo_nxt = frz_lo ? cnt_lo : cnt_lo + 1'b1;
    hi_nxt = (carry && !frz_hi) ? cnt_hi + 1'b1 : cnt_hi;
  end

  assign roll_evt  = advance && carry && !frz_hi && (&cnt_hi);
  assign alarm_evt = advance && ({hi_nxt, lo_nxt} != {cnt_hi, cnt_lo})
                     && ({hi_nxt, lo_nxt} == alarm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (zero || clr) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (tick) begin
      cnt_lo <= lo_nxt;
      cnt_hi <= hi_nxt;
    end
  end
endmodule

// File: rtl/periodic_down.sv
module periodic_down #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         frz,
  input  logic         zero,
  input  logic [W-1:0] reload,
  output logic         expire_evt
);
  logic [W-1:0] cnt;
  logic         step;

  assign step       = en && tick && !frz && !zero;
  assign expire_evt = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (zero || !en)     cnt <= reload;
    else if (step)            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero,
  input  logic [N-1:0] set,
  input  logic [N-1:0] w1c,
  input  logic [N-1:0] en,
  output logic [N-1:0] stat,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat[i] <= 1'b0;
      else if (zero)   stat[i] <= 1'b0;
      else if (set[i]) stat[i] <= 1'b1;
      else if (w1c[i]) stat[i] <= 1'b0;
    end
    assign irq[i] = stat[i] & en[i];
  end
endmodule

// File: rtl/rtc_timer_unit.sv
module rtc_timer_unit
  import rtc_timer_pkg::*;
#(
  parameter int RTC_LO_W = 32,
  parameter int RTC_HI_W = 8,
  parameter int PER_W    = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rtc_tick,
  input  logic        tmr_tick,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_roll,
  output logic        irq_alarm,
  output logic        irq_per
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t                ctrl_q;
  logic [PER_W-1:0]     reload_q;
  logic [RTC_LO_W-1:0]  alm_lo_q, cnt_lo;
  logic [RTC_HI_W-1:0]  alm_hi_q, cnt_hi;
  logic [N_EVT-1:0]     ien_q, stat, irq, set, w1c;
  logic                 ctrl_zero, roll_evt, alarm_evt, per_evt;

  assign ctrl_zero = wr_en && (addr == A_CTRL) && (wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      alm_lo_q <= '0;
      alm_hi_q <= '0;
      ien_q    <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
        A_RELD:  reload_q <= wdata[PER_W-1:0];
        A_ALMLO: alm_lo_q <= wdata[RTC_LO_W-1:0];
        A_ALMHI: alm_hi_q <= wdata[RTC_HI_W-1:0];
        A_IEN:   ien_q    <= wdata[EVT_LSB +: N_EVT];
        default: ;
      endcase
    end
  end

  rtc_count #(.LO_W(RTC_LO_W), .HI_W(RTC_HI_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(rtc_tick), .clr(ctrl_q.clr),
    .zero(ctrl_zero), .frz_lo(ctrl_q.frz_lo), .frz_hi(ctrl_q.frz_hi),
    .alarm({alm_hi_q, alm_lo_q}), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .roll_evt(roll_evt), .alarm_evt(alarm_evt)
  );

  periodic_down #(.W(PER_W)) u_per (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .en(ctrl_q.per_en),
    .frz(ctrl_q.frz_per), .zero(ctrl_zero), .reload(reload_q),
    .expire_evt(per_evt)
  );

  assign set = {roll_evt, alarm_evt, per_evt};
  assign w1c = (wr_en && addr == A_STAT) ? wdata[EVT_LSB +: N_EVT] : '0;

  evt_status #(.N(N_EVT)) u_stat (
    .clk(clk), .rst_n(rst_n), .zero(ctrl_zero), .set(set), .w1c(w1c),
    .en(ien_q), .stat(stat), .irq(irq)
  );

  assign irq_per   = irq[0];
  assign irq_alarm = irq[1];
  assign irq_roll  = irq[2];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[CTRL_W-1:0]        = ctrl_q;
      A_CNTLO: rdata[RTC_LO_W-1:0]      = cnt_lo;
      A_CNTHI: rdata[RTC_HI_W-1:0]      = cnt_hi;
      A_RELD:  rdata[PER_W-1:0]         = reload_q;
      A_ALMLO: rdata[RTC_LO_W-1:0]      = alm_lo_q;
      A_ALMHI: rdata[RTC_HI_W-1:0]      = alm_hi_q;
      A_STAT:  rdata[EVT_LSB +: N_EVT]  = stat;
      A_IEN:   rdata[EVT_LSB +: N_EVT]  = ien_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_timer_chk.sv
module rtc_timer_chk #(
  parameter int LO_W = 32,
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rtc_tick,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [31:0]     wdata,
  input logic [LO_W-1:0] cnt_lo,
  input logic [HI_W-1:0] cnt_hi,
  input logic            ctrl_clr,
  input logic            ctrl_frz_lo,
  input logic            irq_roll,
  input logic            irq_alarm,
  input logic            irq_per
);
  logic ctrl_wr, stat_wr, ien_wr;
  assign ctrl_wr = wr_en && addr == 3'd0;
  assign stat_wr = wr_en && addr == 3'd6;
  assign ien_wr  = wr_en && addr == 3'd7;

  // R4
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr |=> (cnt_lo == '0 && cnt_hi == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtc_tick && !ctrl_wr && !ctrl_clr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  // R3
  lo_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_frz_lo && !ctrl_clr && !ctrl_wr) |=> $stable(cnt_lo));

  // R5
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata == '0) |=> (cnt_lo == '0 && cnt_hi == '0 &&
                                  !irq_roll && !irq_alarm && !irq_per));

  // R10
  sticky_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_per && !stat_wr && !ien_wr && !ctrl_wr) |=> irq_per);
endmodule

bind rtc_timer_unit rtc_timer_chk #(.LO_W(RTC_LO_W), .HI_W(RTC_HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .ctrl_clr(ctrl_q.clr), .ctrl_frz_lo(ctrl_q.frz_lo),
  .irq_roll(irq_roll), .irq_alarm(irq_alarm), .irq_per(irq_per)
);

// File: tb/tb_rtc_timer_unit.sv
module tb_rtc_timer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LO_W = 8;
  localparam int HI_W = 4;

  logic        clk = 0, rst_n = 0, rtc_tick = 0, tmr_tick = 0, wr_en = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq_roll, irq_alarm, irq_per;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_timer_unit #(.RTC_LO_W(LO_W), .RTC_HI_W(HI_W), .PER_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .tmr_tick(tmr_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_roll(irq_roll), .irq_alarm(irq_alarm), .irq_per(irq_per));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rtc_tick = 1;
      @(negedge clk); rtc_tick = 0;
    end
  endtask

  task automatic tticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmr_tick = 1;
      @(negedge clk); tmr_tick = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R1 reg", d, 0);
    end
    check("R1 irq", {irq_roll, irq_alarm, irq_per}, 0);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    rticks(10);
    rd(1, a); check("R2 lo", a, 10);
    rd(2, b); check("R2 hi", b, 0);
    repeat (5) @(negedge clk);
    rd(1, b); check("R2 reread", b, a);
    wr(0, 0); rticks(256);
    rd(2, a); check("R2 carry hi", a, 1);
    rd(1, a); check("R2 carry lo", a, 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    rticks(3);
    wr(0, 32'h10); rticks(4);
    rd(1, d); check("R4 held lo", d, 0);
    rd(2, d); check("R4 held hi", d, 0);
    wr(0, 32'h0); rticks(3);
    rd(1, d); check("R4 resume", d, 3);
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    wr(0, 0); rticks(7);
    wr(0, 32'h04); rticks(300);
    rd(1, d); check("R3 lo frozen", d, 7);
    rd(2, d); check("R3 no carry", d, 0);
    wr(0, 0); rticks(256);
    wr(0, 32'h02); rticks(256);
    rd(2, d); check("R3 hi frozen", d, 1);
    rd(1, d); check("R3 lo runs", d, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(0, 0); wr(3, 3); wr(7, 32'h2000_0000); wr(0, 32'h01);
    tticks(3); check("R6 early", irq_per, 0);
    tticks(1); check("R6 expire", irq_per, 1);
    wr(6, 32'h2000_0000); check("R10 w1c", irq_per, 0);
    tticks(3); check("R6 second early", irq_per, 0);
    tticks(1); check("R6 second", irq_per, 1);
    wr(6, 32'h2000_0000);
    wr(0, 32'h09); tticks(10); check("R7 frozen", irq_per, 0);
    wr(0, 32'h01); tticks(4); check("R7 resumes", irq_per, 1);
    wr(7, 0); check("R10 masked", irq_per, 0);
    rd(6, d); check("R10 unmasked read", d, 32'h2000_0000);
    wr(0, 0); rd(6, d); check("R5 stat clear", d, 0);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    wr(0, 0); wr(4, 5); wr(5, 0); wr(7, 32'h4000_0000);
    rticks(4); check("R8 before", irq_alarm, 0);
    rticks(1); check("R8 match", irq_alarm, 1);
    wr(6, 32'h4000_0000); rticks(3); check("R8 no refire", irq_alarm, 0);
    wr(0, 32'h14); rticks(2); check("R5 nonzero ctrl kept", irq_alarm, 0);
    rd(1, d); check("R4 clr over freeze", d, 0);
    wr(4, 0);
  endtask

  task automatic t_roll();
    logic [31:0] d;
    wr(0, 0); wr(7, 32'h8000_0000);
    rticks(4095); check("R9 before", irq_roll, 0);
    rticks(1); check("R9 wrap", irq_roll, 1);
    rd(1, d); check("R9 lo zero", d, 0);
    wr(7, 0); check("R10 roll masked", irq_roll, 0);
    rd(6, d); check("R10 roll status", d[31], 1);
    rticks(3); wr(0, 0);
    rd(1, d); check("R5 cnt zero", d, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_clear();
    t_freeze();
    t_periodic();
    t_alarm();
    t_roll();
    done = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end
endmodule